// File: doc/BRIEF.md
# Six-Master Bus Arbiter with Mixed Priority and Cascade Slot

This arbiter hands a shared bus to one requester at a time. Six local masters each have a request and grant pair. A seventh slot takes the request of a cascaded downstream arbiter and returns its grant. The slot is handled like any other requester. A 2-bit mode input selects one of three priority schemes: strict fixed priority, fully rotating priority, or a split scheme in which a small top group keeps fixed precedence and the remaining slots rotate among themselves.

Ownership may move only on a clock where the bus is reported idle, or where the current owner signals the end of its transaction. When such a clock arrives with nothing requested, the grant stays parked on the previous owner and a park flag is raised. When nobody has ever been granted and the bus is idle, the arbiter signals that the central agent must drive the idle command and byte-enable lines itself.

The control is a three-state machine:
- `ST_NONE`: no owner.
- `ST_OWNED`: a requester holds the grant.
- `ST_PARKED`: the grant is held with nothing pending.

All transitions happen only on update clocks, where `bus_idle` or `xfer_end` is high:
- Any request moves every state to `ST_OWNED` and regrants the winner.
- No request keeps `ST_NONE` in `ST_NONE`.
- No request moves `ST_OWNED` or `ST_PARKED` to `ST_PARKED`.
- Synchronous reset forces `ST_NONE`.

Top module: `bus_arbiter6`

## Requirements
- R1: At most one of the seven grant lines (`gnt[5:0]`, `ext_gnt`) is high in any clock.
- R2: The grant lines change only after a rising edge at which `bus_idle` or `xfer_end` was sampled high. These are the update edges.
- R3: With `mode_sel` 2'b00, the requesting slot with the lowest index wins an update edge. Slots 0 to 5 are `req[0]` to `req[5]`, and slot 6 is `ext_req`. The reserved code 2'b11 behaves exactly like 2'b00. The rotation pointer is left unchanged in this mode.
- R4: With `mode_sel` 2'b01, the search starts at the rotation pointer and wraps over all seven slots. After a grant to slot w, the pointer becomes w+1, or 0 when w is 6.
- R5: With `mode_sel` 2'b10, slots 0 and 1 win by fixed priority over everything else. Otherwise slots 2 to 6 rotate: the search starts at the pointer, or at 2 if the pointer is below 2. After a grant to slot w of 2 or more, the pointer becomes w+1, or 2 when w is 6. A grant to slot 0 or 1 leaves the pointer unchanged.
- R6: The cascade request `ext_req` competes as slot 6 and is answered only on `ext_gnt`.
- R7: An update edge with no request leaves the existing grant in place. If an owner exists, `park` rises. `park` falls at the next update edge that grants a requester.
- R8: `central_drive` is high exactly when no owner has been granted since reset and `bus_idle` is high.
- R9: A synchronous reset `rst` clears all grants, clears `park` and sets the rotation pointer to slot 0.
- R10: A grant line rises only if its request was high at the update edge that granted it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Priority scheme: 00 fixed, 01 rotating, 10 split, 11 as fixed |
| bus_idle | input | 1 | Bus has no transaction in progress |
| xfer_end | input | 1 | Current owner is in its final data phase |
| req | input | 6 | Requests of masters 0 to 5 |
| ext_req | input | 1 | Request from a cascaded arbiter (slot 6) |
| gnt | output | 6 | Grants to masters 0 to 5 |
| ext_gnt | output | 1 | Grant to the cascaded arbiter |
| park | output | 1 | Grant is parked with no request pending |
| central_drive | output | 1 | No owner and bus idle: the arbiter side drives idle lines |

## Verification
The embedded properties check the following on every clock:
- grant exclusivity;
- that grants move only after update edges;
- that a newly raised grant was requested;
- that park implies an owner;
- the cleared state after reset.

The bench's scenarios show the rest:
- which slot should win, and how the rotation pointer advances under each of the three schemes, through an exhaustive sweep of all 128 request patterns per mode with a bench-side pointer model;
- holding through busy clocks;
- parking;
- that a reset mid-run returns the pointer to slot 0.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        MODE_FIXED  = 2'b00,
        MODE_ROTATE = 2'b01,
        MODE_SPLIT  = 2'b10,
        MODE_RSVD   = 2'b11
    } arb_mode_t;

    typedef enum logic [1:0] {
        ST_NONE   = 2'b00,
        ST_OWNED  = 2'b01,
        ST_PARKED = 2'b10
    } arb_state_t;
endpackage

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
    parameter int N  = 7,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_vec,
    output logic          hit,
    output logic [IW-1:0] hit_idx
);
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req_vec[k]) begin
                hit     = 1'b1;
                hit_idx = IW'(k);
            end
        end
    end
endmodule

// File: rtl/arb_rot_pick.sv
module arb_rot_pick #(
    parameter int N  = 7,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_vec,
    input  logic [IW-1:0] start,
    input  logic [IW-1:0] base,
    output logic          hit,
    output logic [IW-1:0] hit_idx
);
    int span;
    int cand;

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        span    = N - int'(base);
        cand    = 0;
        for (int k = 0; k < N; k++) begin
            if (k < span) begin
                cand = int'(start) + k;
                if (cand >= N) cand = cand - span;
                if (!hit && req_vec[cand]) begin
                    hit     = 1'b1;
                    hit_idx = IW'(cand);
                end
            end
        end
    end
endmodule

// File: rtl/bus_arbiter6.sv
module bus_arbiter6
    import arb_pkg::*;
#(
    parameter int NUM_MASTERS = 6,
    parameter int FIXED_TOP   = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             mode_sel,
    input  logic                   bus_idle,
    input  logic                   xfer_end,
    input  logic [NUM_MASTERS-1:0] req,
    input  logic                   ext_req,
    output logic [NUM_MASTERS-1:0] gnt,
    output logic                   ext_gnt,
    output logic                   park,
    output logic                   central_drive
);
    localparam int NS = NUM_MASTERS + 1;
    localparam int IW = $clog2(NS);
    localparam logic [IW-1:0] LAST_SLOT = IW'(NS - 1);
    localparam logic [IW-1:0] SPLIT_BASE = IW'(FIXED_TOP);

    arb_mode_t  mode;
    arb_state_t state_q, state_d;
    logic [IW-1:0] owner_q, owner_d;
    logic [IW-1:0] ptr_q, ptr_d;
    logic [NS-1:0] req_all, gnt_all;
    logic          any_req, upd;

    logic          fix_hit, rot_hit;
    logic [IW-1:0] fix_idx, rot_idx, rot_base, rot_start, win;

    assign mode    = arb_mode_t'(mode_sel);
    assign req_all = {ext_req, req};
    assign any_req = |req_all;
    assign upd     = bus_idle | xfer_end;

    assign rot_base  = (mode == MODE_SPLIT) ? SPLIT_BASE : '0;
    assign rot_start = (ptr_q < rot_base) ? rot_base : ptr_q;

    arb_fixed_pick #(.N(NS), .IW(IW)) u_fixed (
        .req_vec (req_all),
        .hit     (fix_hit),
        .hit_idx (fix_idx)
    );

    arb_rot_pick #(.N(NS), .IW(IW)) u_rot (
        .req_vec (req_all),
        .start   (rot_start),
        .base    (rot_base),
        .hit     (rot_hit),
        .hit_idx (rot_idx)
    );

    // winner selection and pointer advance
    always_comb begin
        win   = fix_idx;
        ptr_d = ptr_q;
        unique case (mode)
            MODE_ROTATE: begin
                win = rot_idx;
                if (rot_hit) ptr_d = (rot_idx == LAST_SLOT) ? '0 : rot_idx + 1'b1;
            end
            MODE_SPLIT: begin
                if (fix_hit && fix_idx < SPLIT_BASE) begin
                    win = fix_idx;
                end else begin
                    win = rot_idx;
                    if (rot_hit) ptr_d = (rot_idx == LAST_SLOT) ? SPLIT_BASE : rot_idx + 1'b1;
                end
            end
            MODE_FIXED, MODE_RSVD: win = fix_idx;
        endcase
        if (!(upd && any_req)) ptr_d = ptr_q;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        if (upd) begin
            unique case (state_q)
                ST_NONE: begin
                    if (any_req) begin
                        state_d = ST_OWNED;
                        owner_d = win;
                    end
                end
                ST_OWNED, ST_PARKED: begin
                    if (any_req) begin
                        state_d = ST_OWNED;
                        owner_d = win;
                    end else begin
                        state_d = ST_PARKED;
                    end
                end
                default: state_d = ST_NONE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_NONE;
            owner_q <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            ptr_q   <= ptr_d;
        end
    end

    // outputs
    always_comb begin
        gnt_all = '0;
        unique case (state_q)
            ST_OWNED, ST_PARKED: gnt_all[owner_q] = 1'b1;
            default:             gnt_all = '0;
        endcase
        gnt           = gnt_all[NUM_MASTERS-1:0];
        ext_gnt       = gnt_all[NS-1];
        park          = (state_q == ST_PARKED);
        central_drive = (state_q == ST_NONE) && bus_idle;
    end

    // ---------------- assertions ----------------
    assert_one_grant_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ext_gnt, gnt}));

    assert_grant_moves_on_update_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bus_idle) && !$past(xfer_end)) |-> $stable({ext_gnt, gnt}));

    assert_park_has_owner_R7: assert property (@(posedge clk) disable iff (rst)
        park |-> ({ext_gnt, gnt} != '0));

    assert_drive_only_unowned_R8: assert property (@(posedge clk) disable iff (rst)
        central_drive |-> ({ext_gnt, gnt} == '0 && !park));

    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ({ext_gnt, gnt} == '0 && !park));

    generate
        for (genvar i = 0; i < NS; i++) begin : g_req_chk
            assert_grant_requested_R10: assert property (@(posedge clk) disable iff (rst)
                $rose(gnt_all[i]) |-> $past(req_all[i]));
        end
    endgenerate
endmodule

// File: tb/bus_arbiter6_bench.sv
module bus_arbiter6_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode_sel;
    logic       bus_idle, xfer_end;
    logic [5:0] req;
    logic       ext_req;
    logic [5:0] gnt;
    logic       ext_gnt, park, central_drive;

    int checks = 0;
    int errors = 0;
    int m_owner, m_ptr;
    bit m_park;

    always #2 clk = ~clk;

    bus_arbiter6 u_bus_arbiter6 (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .bus_idle(bus_idle),
        .xfer_end(xfer_end), .req(req), .ext_req(ext_req), .gnt(gnt),
        .ext_gnt(ext_gnt), .park(park), .central_drive(central_drive)
    );

    function automatic int pick(input int m, input logic [6:0] v);
        int b, s, c;
        if (v == 0) return -1;
        if (m == 1 || m == 2) begin
            if (m == 2) begin
                if (v[0]) return 0;
                if (v[1]) return 1;
            end
            b = (m == 2) ? 2 : 0;
            s = (m_ptr < b) ? b : m_ptr;
            for (int k = 0; k < 7 - b; k++) begin
                c = b + ((s - b + k) % (7 - b));
                if (v[c]) return c;
            end
            return -1;
        end
        for (int k = 0; k < 7; k++) if (v[k]) return k;
        return -1;
    endfunction

    task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        logic [6:0] ev;
        ev = (m_owner < 0) ? 7'd0 : (7'd1 << m_owner);
        check({tag, " grant"}, {ext_gnt, gnt}, ev);
        check({tag, " park R7"}, {6'd0, park}, {6'd0, m_park});
        check({tag, " drive R8"}, {6'd0, central_drive},
              {6'd0, (m_owner < 0) && bus_idle});
    endtask

    task automatic step(input int m, input logic [6:0] v, input logic idle,
                        input logic xe, input string tag);
        int w;
        @(negedge clk);
        mode_sel = 2'(m); req = v[5:0]; ext_req = v[6]; bus_idle = idle; xfer_end = xe;
        @(posedge clk);
        #1;
        if (idle || xe) begin
            w = pick(m, v);
            if (w >= 0) begin
                m_owner = w;
                m_park  = 1'b0;
                if (m == 1) m_ptr = (w == 6) ? 0 : w + 1;
                else if (m == 2 && w >= 2) m_ptr = (w == 6) ? 2 : w + 1;
            end else if (m_owner >= 0) begin
                m_park = 1'b1;
            end
        end
        compare(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req = '0; ext_req = 1'b0; bus_idle = 1'b1; xfer_end = 1'b0; mode_sel = 2'b00;
        repeat (2) @(posedge clk);
        #1;
        m_owner = -1; m_ptr = 0; m_park = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        compare("R9 reset state");
        @(negedge clk); bus_idle = 1'b0; #1;
        compare("R8 busy no owner");

        // exhaustive sweep; tags: R3 fixed/reserved, R4 rotating, R5 split, R6 cascade slot 6
        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < 128; v++) begin
                step(m, 7'(v), 1'b1, 1'b0,
                     (m == 1) ? "R4 rotate R6" : (m == 2) ? "R5 split R6" : "R3 fixed R6");
            end
        end

        // R2 hold while busy, then move at end of transfer
        step(0, 7'b0000100, 1'b1, 1'b0, "R2 setup");
        step(0, 7'b0000001, 1'b0, 1'b0, "R2 hold busy");
        step(0, 7'b0000001, 1'b0, 1'b0, "R2 hold busy again");
        step(0, 7'b0000001, 1'b0, 1'b1, "R2 move at xfer_end");
        // R7 park and release
        step(0, 7'b0000000, 1'b0, 1'b1, "R7 park");
        step(0, 7'b1000000, 1'b0, 1'b0, "R7 parked busy hold");
        step(0, 7'b1000000, 1'b1, 1'b0, "R7 unpark R6");

        // R9 reset mid-run restores pointer; R4 full rotation
        step(1, 7'b0001000, 1'b1, 1'b0, "R4 move pointer");
        do_reset();
        compare("R9 reset again");
        for (int k = 0; k < 9; k++) step(1, 7'h7F, 1'b1, 1'b0, "R4 R9 rotation from slot 0");
        // R5 split: 0/1 preempt, rotation of the rest continues
        for (int k = 0; k < 6; k++) step(2, 7'b1111100, 1'b1, 1'b0, "R5 split rotate");
        step(2, 7'b1111110, 1'b1, 1'b0, "R5 fixed top wins");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule